// File: doc/BRIEF.md
# PHI2 Bus Access Sequencer

This block sits between a simple host request port and a small static RAM that latches its address on the rising edge of a PHI2 strobe. Each host request, a read or a write of one 4-bit nibble at a 10-bit address, becomes one complete, ordered access cycle on the memory pins. Every access starts and ends with PHI2 low and the memory deselected. The sequencer drives address, direction and R/W first, and only then asserts select. It then holds a timed address-setup interval, raises PHI2 for a timed access window, samples the read nibble while PHI2 is still high, and tears down in the opposite order.

The two waits are counted in system clock cycles. Each wait count is the smallest number of cycles whose total duration is strictly longer than the nanosecond minimum, derived from the clock period parameter. The host sees a one-cycle acknowledge at the end of each access. New requests are taken only when the sequencer is idle.

The state machine has seven states. IDLE goes to DRIVE when a request arrives. DRIVE goes to SETUP after one cycle. SETUP goes to ACCESS when the setup count expires. ACCESS goes to LOWER when the window count expires, and the read sample is taken on that transition. LOWER goes to RELEASE after one cycle. RELEASE goes to DONE after one cycle. DONE returns to IDLE after one cycle.

Top module: `phi2_seq`

## Requirements
- R1: Out of reset and whenever the sequencer is idle, `mem_phi2`, `mem_sel`, `mem_doe` and `ack` are 0 and `mem_rw` is 1 (1 = read, 0 = write).
- R2: In the first cycle after a request is taken, `mem_addr` shows the request address and `mem_rw` shows the direction, while `mem_sel` and `mem_phi2` are still 0.
- R3: `mem_sel` is then held at 1 with `mem_phi2` at 0 for SETUP_CYC = SETUP_NS/CLK_NS + 1 cycles (integer division), which always lasts strictly longer than SETUP_NS.
- R4: `mem_phi2` is then held at 1 for ACCESS_CYC = ACCESS_NS/CLK_NS + 1 cycles, while select, address and R/W stay unchanged.
- R5: For a read, the value on `mem_din` during the last PHI2-high cycle is the value returned on `rsp_rdata` in the acknowledge cycle.
- R6: For a write, `mem_doe` is 1 and `mem_dout` carries the write nibble from the cycle before select through the cycle in which select falls, and `mem_rw` is 0 throughout.
- R7: Teardown takes one cycle with `mem_phi2` at 0 and `mem_sel` still at 1, then one cycle with `mem_sel` at 0.
- R8: `ack` is 1 for exactly one cycle, the cycle after the deselect cycle. `mem_doe` is 0 in that cycle.
- R9: A request that is asserted while an access is in progress, including during the `ack` cycle, is not taken until the following idle cycle.
- R10: `mem_doe` is never 1 during a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, sampled only in idle |
| req_addr | input | 10 | Host nibble address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Host write nibble |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read nibble, valid while `ack` is 1 |
| mem_phi2 | output | 1 | Memory PHI2 strobe |
| mem_sel | output | 1 | Memory select, active high |
| mem_rw | output | 1 | Memory R/W, 1 = read |
| mem_addr | output | 10 | Memory address |
| mem_dout | output | 4 | Nibble driven toward the memory |
| mem_doe | output | 1 | Enable for `mem_dout` onto the data bus |
| mem_din | input | 4 | Nibble read from the data bus |

## Verification
Two events can fall in the same cycle. The read sample lands on the same clock edge at which PHI2 falls. The acknowledge cycle can also coincide with a request that the host keeps asserted. The bench memory drives the true nibble only while selected, PHI2 high and R/W high, and drives its complement otherwise, so a sample taken one cycle late returns the wrong value. Back-to-back transfers keep `req` high straight through `ack`. The behavioural model must then see the new request ignored in DONE and taken one idle cycle later, and it compares every pin on every clock.

// File: rtl/phi2_seq_pkg.sv
package phi2_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_SETUP,
        ST_ACCESS,
        ST_LOWER,
        ST_RELEASE,
        ST_DONE
    } seq_state_e;

    // smallest cycle count whose duration strictly exceeds min_ns
    function automatic int unsigned cycles_over(input int unsigned min_ns,
                                                input int unsigned period_ns);
        return (min_ns / period_ns) + 1;
    endfunction

endpackage

// File: rtl/phi2_wait_timer.sv
module phi2_wait_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/phi2_req_latch.sv
module phi2_req_latch #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              take_rd,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] addr_q,
    output logic              we_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (take_req) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take_rd) begin
            rdata_q <= bus_din;
        end
    end

endmodule

// File: rtl/phi2_seq.sv
module phi2_seq
    import phi2_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 4,
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned SETUP_NS  = 200,
    parameter int unsigned ACCESS_NS = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_phi2,
    output logic              mem_sel,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int unsigned SETUP_CYC  = cycles_over(SETUP_NS, CLK_NS);
    localparam int unsigned ACCESS_CYC = cycles_over(ACCESS_NS, CLK_NS);
    localparam int unsigned MAX_CYC    = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_e state_q, state_d;

    logic              take_req, take_rd;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    phi2_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    phi2_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (take_req),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .take_rd   (take_rd),
        .bus_din   (mem_din),
        .addr_q    (addr_q),
        .we_q      (we_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and step controls
    always_comb begin
        state_d  = state_q;
        take_req = 1'b0;
        take_rd  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    take_req = 1'b1;
                    state_d  = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETUP_CYC - 1);
                state_d  = ST_SETUP;
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ACCESS_CYC - 1);
                    state_d  = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (tmr_zero) begin
                    take_rd = ~we_q;
                    state_d = ST_LOWER;
                end
            end
            ST_LOWER:   state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // memory-side and host-side outputs
    always_comb begin
        mem_phi2 = 1'b0;
        mem_sel  = 1'b0;
        mem_rw   = 1'b1;
        mem_doe  = 1'b0;
        ack      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRIVE: begin
                mem_rw  = ~we_q;
                mem_doe = we_q;
            end
            ST_SETUP: begin
                mem_sel = 1'b1;
                mem_rw  = ~we_q;
                mem_doe = we_q;
            end
            ST_ACCESS: begin
                mem_phi2 = 1'b1;
                mem_sel  = 1'b1;
                mem_rw   = ~we_q;
                mem_doe  = we_q;
            end
            ST_LOWER: begin
                mem_sel = 1'b1;
                mem_rw  = ~we_q;
                mem_doe = we_q;
            end
            ST_RELEASE: begin
                mem_rw  = ~we_q;
                mem_doe = we_q;
            end
            ST_DONE: ack = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dout = wdata_q;

endmodule

// File: rtl/phi2_seq_chk.sv
module phi2_seq_chk #(
    parameter int unsigned ACCESS_CYC = 21,
    parameter int unsigned ADDR_W     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              mem_phi2,
    input logic              mem_sel,
    input logic              mem_rw,
    input logic              mem_doe,
    input logic [ADDR_W-1:0] mem_addr
);

    int unsigned high_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= 0;
        end else if (mem_phi2) begin
            high_run <= high_run + 1;
        end else begin
            high_run <= 0;
        end
    end

    // R2
    sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sel) |-> (!mem_phi2 && $stable(mem_addr) && $stable(mem_rw)));

    // R4
    phi2_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_phi2 |-> mem_sel);

    // R4
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_phi2) |-> (high_run == ACCESS_CYC));

    // R7
    phi2_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_sel) |-> $past(!mem_phi2));

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R8
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!mem_sel && !mem_doe && !mem_phi2));

    // R10
    doe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> !mem_rw);

    // R6
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel && !mem_rw) |-> mem_doe);

endmodule

bind phi2_seq phi2_seq_chk #(.ACCESS_CYC(ACCESS_CYC), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .mem_phi2 (mem_phi2),
    .mem_sel  (mem_sel),
    .mem_rw   (mem_rw),
    .mem_doe  (mem_doe),
    .mem_addr (mem_addr)
);

// File: tb/tb_phi2_seq.sv
module tb_phi2_seq;

    localparam int CLK_PERIOD = 20;
    localparam int SETUP_NS   = 200;
    localparam int ACCESS_NS  = 400;
    localparam int S_CYC      = SETUP_NS / CLK_PERIOD + 1;
    localparam int A_CYC      = ACCESS_NS / CLK_PERIOD + 1;
    localparam int LAST_T     = S_CYC + A_CYC + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [9:0] req_addr = '0;
    logic       req_we = 1'b0;
    logic [3:0] req_wdata = '0;
    logic       ack, mem_phi2, mem_sel, mem_rw, mem_doe;
    logic [3:0] rsp_rdata, mem_dout, mem_din;
    logic [9:0] mem_addr;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    logic [3:0] mem [1024];

    // model state
    bit         m_busy = 0;
    int         m_t = 0;
    logic [9:0] m_addr = '0;
    logic       m_we = 0;
    logic [3:0] m_wd = '0;
    logic [3:0] m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phi2_seq #(.CLK_NS(CLK_PERIOD), .SETUP_NS(SETUP_NS), .ACCESS_NS(ACCESS_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_we(req_we),
        .req_wdata(req_wdata), .ack(ack), .rsp_rdata(rsp_rdata), .mem_phi2(mem_phi2),
        .mem_sel(mem_sel), .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_din(mem_din)
    );

    // bus memory: true nibble only when selected, PHI2 high, reading
    assign mem_din = (mem_sel && mem_phi2 && mem_rw) ? mem[mem_addr] : ~mem[mem_addr];

    always @(negedge mem_phi2) begin
        if (mem_sel && !mem_rw) mem[mem_addr] = mem_dout;
    end

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0;
        end else if (m_busy) begin
            if (m_t == S_CYC + A_CYC && !m_we) m_rd = mem[m_addr];   // R5
            if (m_t == LAST_T) m_busy = 0;
            else m_t++;
        end else if (req) begin
            m_busy = 1; m_t = 0;
            m_addr = req_addr; m_we = req_we; m_wd = req_wdata;
        end
    end

    function automatic string phase_tag();
        if (!m_busy)                       return "R1";
        if (m_t == 0)                      return "R2";
        if (m_t <= S_CYC)                  return "R3";
        if (m_t <= S_CYC + A_CYC)          return "R4";
        if (m_t <= S_CYC + A_CYC + 2)      return "R7";
        return "R8";
    endfunction

    task automatic chk(input string tag, input string what, input logic [9:0] act,
                       input logic [9:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s t=%0d actual=%0h expected=%0h", tag, what, m_t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin : cmp
            bit e_phi2, e_sel, e_rw, e_doe, e_ack, in_win;
            string tg;
            tg     = phase_tag();
            if (req && m_busy) tg = {tg, "/R9"};
            in_win = m_busy && m_t <= S_CYC + A_CYC + 2;
            e_phi2 = m_busy && m_t > S_CYC && m_t <= S_CYC + A_CYC;
            e_sel  = m_busy && m_t >= 1 && m_t <= S_CYC + A_CYC + 1;
            e_rw   = in_win ? !m_we : 1'b1;
            e_doe  = in_win && m_we;
            e_ack  = m_busy && m_t == LAST_T;
            chk(tg, "phi2", 10'(mem_phi2), 10'(e_phi2));
            chk(tg, "sel",  10'(mem_sel),  10'(e_sel));
            chk(tg, "rw",   10'(mem_rw),   10'(e_rw));
            chk(m_we ? "R6" : "R10", "doe", 10'(mem_doe), 10'(e_doe));
            chk(tg, "ack",  10'(ack),      10'(e_ack));
            if (in_win) chk(tg, "addr", mem_addr, m_addr);
            if (in_win && m_we) chk("R6", "dout", 10'(mem_dout), 10'(m_wd));
            if (e_ack && !m_we) chk("R5", "rdata", 10'(rsp_rdata), 10'(m_rd));
        end
    end

    task automatic xfer(input logic [9:0] a, input logic we, input logic [3:0] d,
                        input bit hold);
        req = 1'b1; req_addr = a; req_we = we; req_wdata = d;
        do @(negedge clk); while (!ack);
        if (!hold) req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 4'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "phi2", 10'(mem_phi2), 10'd0);
        chk("R1", "sel",  10'(mem_sel),  10'd0);
        chk("R1", "doe",  10'(mem_doe),  10'd0);
        chk("R1", "ack",  10'(ack),      10'd0);
        chk("R1", "rw",   10'(mem_rw),   10'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        xfer(10'd0,    1'b0, 4'h0, 0);   // read preloaded
        xfer(10'd0,    1'b1, 4'h5, 0);
        xfer(10'd1023, 1'b1, 4'hF, 0);
        xfer(10'd0,    1'b0, 4'h0, 0);
        xfer(10'd1023, 1'b0, 4'h0, 0);
        xfer(10'd512,  1'b0, 4'h0, 0);
        repeat (3) @(negedge clk);
        // R9: request held through ack, back to back
        xfer(10'd5,   1'b1, 4'hA, 1);
        xfer(10'd5,   1'b0, 4'h0, 1);
        xfer(10'd6,   1'b1, 4'h3, 1);
        xfer(10'd6,   1'b0, 4'h0, 0);
        begin : mix
            logic [9:0] lf;
            lf = 10'h2B5;
            for (int k = 0; k < 10; k++) begin
                lf = {lf[8:0], lf[9] ^ lf[6]};
                xfer(lf, lf[0], lf[7:4], k[0]);
            end
        end
        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        miscompares++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule